// File: doc/BRIEF.md
# Bounded-Poll Storage Word Reader

This block reads a run of 16-bit words from a non-volatile storage array. Its storage side works like a register pair. To start one word read, the block writes a command word that holds the word address and a start bit. It then reads back a status word until the done flag is seen. When done is seen, it takes the data from the upper half of that status word. A client asks for a run of words by giving a start offset and a word count. The words come back one at a time, each with a valid pulse and its address.

Before any storage access, the block checks that the requested run lies inside the array. A request that fails this check is answered at once with an error, and no command is written. Each word gets a fixed polling budget: at most `POLL_MAX` samples of the status word, with `POLL_GAP` idle cycles before each sample. If a word uses up its budget without done, the whole run stops at that word and the error is reported.

Top module: `nvm_word_reader`

## Requirements
- R1: A request is rejected when the offset is not below `WORDS`, when the count is zero, or when the count exceeds `WORDS` minus the offset. A rejection raises `burst_done` and `burst_err` together for one cycle, on the clock edge that accepts the request, and writes no storage command.
- R2: An accepted request reads its words one at a time at consecutive addresses, starting from the requested offset. Each word is delivered on `word_valid` with its address on `word_addr`.
- R3: Each word read is launched by a single-cycle `nvm_cmd_we` pulse. The command word carries the word address in bits [2 +: AW], a 1 in bit 0 (start) and a 0 in bit 1.
- R4: The status word is sampled `POLL_GAP`+1 cycles after the command write, and again every `POLL_GAP`+1 cycles after that, for at most `POLL_MAX` samples per word. Bit 1 of the status word is the done flag.
- R5: The delivered word is bits 31:16 of the status word, taken on the sample where done is seen.
- R6: If done is not seen within the budget, `burst_done` and `burst_err` pulse, no further words are delivered and no further commands are written.
- R7: A run that completes raises `burst_done` with `burst_err` low, in the same cycle as the last `word_valid`.
- R8: `busy` is high from the accepting edge until the edge that raises `burst_done`. A `req_valid` pulse while `busy` is high is ignored.
- R9: After reset, `busy`, `word_valid`, `burst_done`, `burst_err` and `nvm_cmd_we` are low.
- R10: A word that needs a samples is delivered 4+`POLL_GAP`+(a-1)(`POLL_GAP`+1) cycles after the edge that accepted the request, or after the previous word was delivered. A timeout error comes at the same offset with a = `POLL_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_offset | input | AW | First word address |
| req_count | input | CW | Number of words to read |
| busy | output | 1 | Run in progress |
| word_valid | output | 1 | One-cycle pulse for each delivered word |
| word_addr | output | AW | Address of the delivered word |
| word_data | output | 16 | Delivered word |
| burst_done | output | 1 | One-cycle pulse when the run ends |
| burst_err | output | 1 | Error flag, valid with burst_done |
| nvm_cmd | output | 32 | Command word to storage |
| nvm_cmd_we | output | 1 | Command write strobe |
| nvm_stat | input | 32 | Status/data word from storage |

## Verification
The bench counts the clock edges that follow each accepting edge. A rejection is due on that same edge. Each word is due 4+`POLL_GAP`+(a-1)(`POLL_GAP`+1) edges after the previous reference point, where a is the number of samples the storage model's latency for that address forces. A timeout is due at the same offset with a = `POLL_MAX`. The bench reads outputs at falling edges, and each event must land exactly on its predicted edge, with the address, the data and the total number of command writes checked as well. The latency of the storage model is chosen for each request, and for each address when a mid-run stall is wanted. This lets first-sample reads, last-sample reads and timeouts fall on known edges.

// File: rtl/nvm_rd_pkg.sv
// Shared constants and state types for the storage word reader.
// Assumes a 32-bit command/status register pair on the storage side.
package nvm_rd_pkg;
    localparam int START_BIT = 0;
    localparam int DONE_BIT  = 1;
    localparam int ADDR_LSB  = 2;
    localparam int DATA_LSB  = 16;

    typedef enum logic [1:0] {
        P_IDLE,
        P_LAUNCH,
        P_WAIT,
        P_CHECK
    } poll_state_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_RUN
    } seq_state_t;
endpackage

// File: rtl/nvm_req_check.sv
// Range check for a read request: the offset must lie inside the array,
// the count must be non-zero and must fit in the words left after the offset.
// Purely combinational; assumes WORDS fits in 31 bits.
module nvm_req_check #(
    parameter int AW    = 6,
    parameter int CW    = 7,
    parameter int WORDS = 48
) (
    input  logic [AW-1:0] offset,
    input  logic [CW-1:0] count,
    output logic          in_range
);
    logic [31:0] off_w;
    logic [31:0] cnt_w;

    // Widen both operands so that the remaining-words subtraction cannot wrap.
    always_comb begin
        off_w    = 32'(offset);
        cnt_w    = 32'(count);
        in_range = (off_w < 32'(WORDS)) && (cnt_w != 32'd0) &&
                   (cnt_w <= (32'(WORDS) - off_w));
    end
endmodule

// File: rtl/nvm_poll_unit.sv
// Single-word read engine: writes one command with the start bit, then
// samples the status word after POLL_GAP idle cycles, up to POLL_MAX times.
// Reports either ok (with data) or tmo as a one-cycle pulse.
// Assumes go is only raised while idle is high, POLL_GAP >= 1, POLL_MAX >= 1.
module nvm_poll_unit
    import nvm_rd_pkg::*;
#(
    parameter int AW       = 6,
    parameter int POLL_MAX = 4,
    parameter int POLL_GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   stat,
    output logic [31:0]   cmd,
    output logic          cmd_we,
    output logic          idle,
    output logic          ok,
    output logic          tmo,
    output logic [15:0]   data
);
    localparam int ATT_W = $clog2(POLL_MAX + 1);
    localparam int GAP_W = $clog2(POLL_GAP + 1);

    poll_state_t       ps_q;
    logic [AW-1:0]     addr_q;
    logic [ATT_W-1:0]  att_q;
    logic [GAP_W-1:0]  gap_q;
    logic              unused_stat;

    assign unused_stat = ^{stat[DATA_LSB-1:DONE_BIT+1], stat[START_BIT]};

    // Command word and strobe exist only in the launch cycle.
    always_comb begin
        idle   = (ps_q == P_IDLE);
        cmd_we = (ps_q == P_LAUNCH);
        cmd    = cmd_we ? ((32'(addr_q) << ADDR_LSB) | (32'd1 << START_BIT)) : '0;
    end

    // Launch, wait, sample sequence with gap and attempt counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q   <= P_IDLE;
            addr_q <= '0;
            att_q  <= '0;
            gap_q  <= '0;
            ok     <= 1'b0;
            tmo    <= 1'b0;
            data   <= '0;
        end else begin
            ok  <= 1'b0;
            tmo <= 1'b0;
            unique case (ps_q)
                P_IDLE: begin
                    if (go) begin
                        addr_q <= addr;
                        att_q  <= '0;
                        ps_q   <= P_LAUNCH;
                    end
                end
                P_LAUNCH: begin
                    gap_q <= '0;
                    ps_q  <= P_WAIT;
                end
                P_WAIT: begin
                    if (gap_q == GAP_W'(POLL_GAP - 1)) begin
                        gap_q <= '0;
                        ps_q  <= P_CHECK;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                P_CHECK: begin
                    if (stat[DONE_BIT]) begin
                        ok   <= 1'b1;
                        data <= stat[DATA_LSB +: 16];
                        ps_q <= P_IDLE;
                    end else if (att_q == ATT_W'(POLL_MAX - 1)) begin
                        tmo  <= 1'b1;
                        ps_q <= P_IDLE;
                    end else begin
                        att_q <= att_q + 1'b1;
                        ps_q  <= P_WAIT;
                    end
                end
                default: ps_q <= P_IDLE;
            endcase
        end
    end

    // R4
    att_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        att_q < ATT_W'(POLL_MAX));

    // R3
    single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> !cmd_we);

    // R4
    check_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_q == P_CHECK) |-> ($past(ps_q) == P_WAIT));
endmodule

// File: rtl/nvm_word_reader.sv
// Top level: accepts a (offset, count) request, range-checks it, then walks
// consecutive addresses through the poll unit, streaming each word out.
// Stops the run at the first word that exhausts its polling budget.
// Assumes storage holds WORDS 16-bit words addressed 0..WORDS-1.
module nvm_word_reader
    import nvm_rd_pkg::*;
#(
    parameter int AW       = 6,
    parameter int CW       = 7,
    parameter int WORDS    = 48,
    parameter int POLL_MAX = 4,
    parameter int POLL_GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_offset,
    input  logic [CW-1:0] req_count,
    output logic          busy,
    output logic          word_valid,
    output logic [AW-1:0] word_addr,
    output logic [15:0]   word_data,
    output logic          burst_done,
    output logic          burst_err,
    output logic [31:0]   nvm_cmd,
    output logic          nvm_cmd_we,
    input  logic [31:0]   nvm_stat
);
    seq_state_t     ss_q;
    logic [AW-1:0]  cur_q;
    logic [CW-1:0]  left_q;
    logic           in_range;
    logic           pu_go;
    logic           pu_idle;
    logic           pu_ok;
    logic           pu_tmo;
    logic [15:0]    pu_data;

    nvm_req_check #(.AW(AW), .CW(CW), .WORDS(WORDS)) u_chk (
        .offset   (req_offset),
        .count    (req_count),
        .in_range (in_range)
    );

    nvm_poll_unit #(.AW(AW), .POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (pu_go),
        .addr   (cur_q),
        .stat   (nvm_stat),
        .cmd    (nvm_cmd),
        .cmd_we (nvm_cmd_we),
        .idle   (pu_idle),
        .ok     (pu_ok),
        .tmo    (pu_tmo),
        .data   (pu_data)
    );

    // Hand one address to the poll unit per issue cycle.
    assign pu_go = (ss_q == S_ISSUE) && pu_idle;

    // Run sequencing: accept/reject, per-word advance, completion and abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_q       <= S_IDLE;
            cur_q      <= '0;
            left_q     <= '0;
            busy       <= 1'b0;
            word_valid <= 1'b0;
            word_addr  <= '0;
            word_data  <= '0;
            burst_done <= 1'b0;
            burst_err  <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            burst_done <= 1'b0;
            burst_err  <= 1'b0;
            unique case (ss_q)
                S_IDLE: begin
                    if (req_valid) begin
                        if (in_range) begin
                            cur_q  <= req_offset;
                            left_q <= req_count;
                            busy   <= 1'b1;
                            ss_q   <= S_ISSUE;
                        end else begin
                            burst_done <= 1'b1;
                            burst_err  <= 1'b1;
                        end
                    end
                end
                S_ISSUE: begin
                    if (pu_idle) ss_q <= S_RUN;
                end
                S_RUN: begin
                    if (pu_ok) begin
                        word_valid <= 1'b1;
                        word_addr  <= cur_q;
                        word_data  <= pu_data;
                        if (left_q == CW'(1)) begin
                            burst_done <= 1'b1;
                            busy       <= 1'b0;
                            ss_q       <= S_IDLE;
                        end else begin
                            cur_q  <= cur_q + 1'b1;
                            left_q <= left_q - 1'b1;
                            ss_q   <= S_ISSUE;
                        end
                    end else if (pu_tmo) begin
                        burst_done <= 1'b1;
                        burst_err  <= 1'b1;
                        busy       <= 1'b0;
                        ss_q       <= S_IDLE;
                    end
                end
                default: ss_q <= S_IDLE;
            endcase
        end
    end

    // R6
    tmo_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pu_tmo |=> (burst_done && burst_err && !word_valid && !busy));

    // R1
    err_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_err |-> burst_done);

    // R7
    clean_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && burst_done) |-> !burst_err);

    // R3
    we_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_cmd_we |-> busy);

    // R8
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> !busy);
endmodule

// File: tb/sim_nvm_word_reader.sv
module sim_nvm_word_reader;
    localparam int AW = 6;
    localparam int CW = 7;
    localparam int W  = 48;
    localparam int P  = 4;
    localparam int G  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_offset = '0;
    logic [CW-1:0] req_count = '0;
    logic          busy, word_valid, burst_done, burst_err, nvm_cmd_we;
    logic [AW-1:0] word_addr;
    logic [15:0]   word_data;
    logic [31:0]   nvm_cmd, nvm_stat;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nvm_word_reader #(.AW(AW), .CW(CW), .WORDS(W), .POLL_MAX(P), .POLL_GAP(G)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_count(req_count), .busy(busy), .word_valid(word_valid),
        .word_addr(word_addr), .word_data(word_data), .burst_done(burst_done),
        .burst_err(burst_err), .nvm_cmd(nvm_cmd), .nvm_cmd_we(nvm_cmd_we),
        .nvm_stat(nvm_stat)
    );

    // storage model: latency per address, done after the latency elapses
    int base_lat = 0;
    int slow_addr = -1;
    int m_addr = 0;
    int lcnt = 0;
    bit pend = 1'b0;
    int wr_cnt = 0;
    bit bad_cmd = 1'b0;

    function automatic logic [15:0] mem_of(int a);
        return 16'(a * 32'h3D07) ^ 16'hB2E1;
    endfunction

    function automatic int lat_of(int a);
        return (a == slow_addr) ? 1000 : base_lat;
    endfunction

    function automatic int att_of(int lat);
        return 1 + lat / (G + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            lcnt <= 0;
        end else if (nvm_cmd_we) begin
            m_addr <= int'(nvm_cmd[2 +: AW]);
            lcnt   <= lat_of(int'(nvm_cmd[2 +: AW]));
            pend   <= 1'b1;
            wr_cnt <= wr_cnt + 1;
            if (nvm_cmd[0] !== 1'b1 || nvm_cmd[1] !== 1'b0) bad_cmd <= 1'b1;
        end else if (lcnt > 0) begin
            lcnt <= lcnt - 1;
        end
    end

    assign nvm_stat = {mem_of(m_addr), 14'b0, (pend && lcnt == 0), 1'b0};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, exp, cyc);
        end
    endtask

    task automatic do_req(input int off, input int cnt, input int blat,
                          input int slow, input bit poke);
        int acc, prev, nw, fin_t, wr0, k, at;
        bit valid, err_exp, seen;
        int exp_t[128];
        base_lat  = blat;
        slow_addr = slow;
        valid = !(off >= W || cnt == 0 || cnt > W - off);
        @(negedge clk);
        req_valid  = 1'b1;
        req_offset = AW'(off);
        req_count  = CW'(cnt);
        acc = cyc + 1;
        wr0 = wr_cnt;
        nw = 0;
        err_exp = 1'b0;
        fin_t = acc;
        if (!valid) begin
            err_exp = 1'b1;
        end else begin
            prev = acc;
            for (int i = 0; i < cnt; i++) begin
                at = att_of(lat_of(off + i));
                if (at > P) begin
                    err_exp = 1'b1;
                    fin_t = prev + 4 + G + (P - 1) * (G + 1);
                    break;
                end
                exp_t[i] = prev + 4 + G + (at - 1) * (G + 1);
                prev = exp_t[i];
                nw++;
                fin_t = prev;
            end
        end
        k = 0;
        seen = 1'b0;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            req_valid = poke && (cyc == acc + 1);
            if (req_valid) req_offset = '0;
            if (word_valid) begin
                if (k >= nw) begin
                    chk(1'b0, "R6 extra word", k, nw);
                end else begin
                    chk(cyc == exp_t[k], "R10 word timing", cyc, exp_t[k]);
                    chk(int'(word_addr) == off + k, "R2 word address", int'(word_addr), off + k);
                    chk(word_data == mem_of(off + k), "R5 word data", int'(word_data),
                        int'(mem_of(off + k)));
                end
                k++;
            end
            if (burst_done) begin
                chk(cyc == fin_t, valid ? "R7 done timing" : "R1 reject timing", cyc, fin_t);
                chk(burst_err == err_exp, valid ? "R6 error flag" : "R1 error flag",
                    int'(burst_err), int'(err_exp));
                chk(k == nw, "R2 word count", k, nw);
                chk(!busy, "R8 busy released", int'(busy), 0);
                chk(wr_cnt - wr0 == nw + ((valid && err_exp) ? 1 : 0), "R3 command writes",
                    wr_cnt - wr0, nw + ((valid && err_exp) ? 1 : 0));
                chk(!bad_cmd, "R3 command bits", int'(bad_cmd), 0);
                seen = 1'b1;
                break;
            end
            if (busy != valid) chk(1'b0, "R8 busy during run", int'(busy), int'(valid));
        end
        req_valid = 1'b0;
        if (!seen) chk(1'b0, "R6 run never ended", 0, 1);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int off, cnt, lat, slow;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!busy && !word_valid && !burst_done && !burst_err && !nvm_cmd_we,
            "R9 reset state", int'({busy, word_valid, burst_done, burst_err, nvm_cmd_we}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corners
        do_req(0, 4, 0, -1, 1'b0);        // R2 first-sample reads
        do_req(47, 1, 1, -1, 1'b0);       // last address
        do_req(48, 1, 0, -1, 1'b0);       // R1 offset at size
        do_req(10, 0, 0, -1, 1'b0);       // R1 zero count
        do_req(40, 9, 0, -1, 1'b0);       // R1 count too large
        do_req(40, 8, 0, -1, 1'b0);       // exact fit
        do_req(3, 127, 0, -1, 1'b0);      // R1 max count
        do_req(5, 3, 11, -1, 1'b0);       // R4 done on last sample
        do_req(5, 3, 12, -1, 1'b0);       // R6 timeout on first word
        do_req(20, 6, 3, 23, 1'b0);       // R6 abort mid-run
        do_req(30, 5, 4, -1, 1'b1);       // R8 request while busy
        // random mix
        for (int i = 0; i < 40; i++) begin
            off  = int'($urandom_range(0, 55));
            cnt  = int'($urandom_range(0, 9));
            lat  = int'($urandom_range(0, 13));
            slow = ($urandom_range(0, 4) == 0) ? off + int'($urandom_range(0, 8)) : -1;
            do_req(off, cnt, lat, slow, 1'($urandom_range(0, 1)));
        end
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule